// File: doc/BRIEF.md
# Oversampled I2C Target with Sticky Register Pointer

This block is an I2C/SMBus target that runs entirely on a fast system clock. It oversamples the SCL and SDA lines and passes each one through a stability filter. It then recognises START, repeated START and STOP conditions. It responds to one fixed 7-bit address and returns ACKs and read data through an open-drain pull-down enable, `sda_oe_o`. The pad drives SDA low whenever that enable is high.

The first byte written after the address is a command byte. Its two low bits select one of four registers in an external register bank. The block reaches that bank through a select, a write strobe with write data, and a read strobe with read data.

The selection is sticky. It survives STOP and is never advanced by data traffic. Consecutive data bytes in a write therefore land on the same register. Reads return that register until a new command byte arrives. A master reads a chosen register by sending the address with write, then the command byte, then a repeated START, then the address with read.

Top module: `i2c_cmd_target`

## Requirements
- R1: After reset, `sda_oe_o` is low, `reg_wr_o` and `reg_rd_o` are low, and `reg_sel_o` is 0.
- R2: The target ACKs only the address 7'b1001001, which is sent MSB first and followed by the R/W bit (1 = read), by driving SDA low in the ninth clock. For any other address it leaves SDA released for the rest of that transfer, and no write strobe results.
- R3: The first byte after an address with write is the command byte. Its bits 1..0 become `reg_sel_o` and bits 7..2 are ignored. The command byte itself produces no write strobe.
- R4: Every further data byte in the same write produces exactly one single-cycle `reg_wr_o` to the same selected register. The pointer never increments, and other registers are not written.
- R5: The selection persists across STOP. A later read that sends no command byte returns the same register for every byte read.
- R6: A read transfers the register value MSB first. The target pulses `reg_rd_o` and loads `reg_rdata_i` while SCL is low at the start of each byte it sends.
- R7: When the master NACKs a read byte, the target releases SDA and loads no further byte.
- R8: A STOP at any point returns the target to idle with SDA released. A byte cut short by a STOP is not written.
- R9: The write strobe for a data byte occurs during the acknowledge clock of that byte: after its eighth data bit and while SCL is high in the ninth clock.
- R10: Pulses on SCL or SDA shorter than `FILT_CYC` system clocks (8 clocks = 64 ns at 125 MHz) are ignored. They neither clock data nor form START or STOP.
- R11: `sda_oe_o` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System oversampling clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Raw SCL line level |
| sda_i | input | 1 | Raw SDA line level |
| sda_oe_o | output | 1 | Pull SDA low when high |
| reg_sel_o | output | 2 | Selected register index (command pointer) |
| reg_wr_o | output | 1 | One-cycle write strobe |
| reg_wdata_o | output | 8 | Data for the write strobe |
| reg_rd_o | output | 1 | One-cycle read-load strobe |
| reg_rdata_i | input | 8 | Data of the selected register |

## Verification
The bench targets four failure modes.

- Pointer stickiness: it issues a three-byte write and follows it with a three-byte read that sends no command byte. A design that auto-incremented would spread the bytes over three registers, and the read-back would expose it.
- Wrong address: it sends a non-matching address followed by bytes. A design with a loose address compare would ACK and would emit a write strobe.
- Truncated byte: a STOP cut into the middle of a byte. A design without STOP handling there would keep driving SDA or would write a partial byte.
- Glitches and timing: it injects sub-filter pulses on SCL in a low phase and on SDA in a high phase. An unfiltered design would shift an extra bit or would see a false START and abort the byte. It also samples the write-strobe count in the middle of the ACK clock to catch a strobe that comes a byte late.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int BYTE_W = 8;
  localparam int REG_N  = 4;
  localparam int PTR_W  = $clog2(REG_N);
  localparam int BCNT_W = $clog2(BYTE_W) + 1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_RX,
    ST_RACK,
    ST_TX,
    ST_MACK
  } tgt_state_e;
endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
  parameter int FILT_CYC = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic flt_o
);
  localparam int CNT_W = $clog2(FILT_CYC + 1);

  logic [1:0]       sync_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b11;
      cnt_q  <= '0;
      flt_o  <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], raw_i};
      if (sync_q[1] == flt_o) begin
        cnt_q <= '0;
      end else if (cnt_q == CNT_W'(FILT_CYC - 1)) begin
        cnt_q <= '0;
        flt_o <= sync_q[1];
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  // R10
  flt_settle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(flt_o) |-> ($past(sync_q[1]) == flt_o));
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_f_i,
  input  logic sda_f_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_p_q, sda_p_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_p_q <= 1'b1;
      sda_p_q <= 1'b1;
    end else begin
      scl_p_q <= scl_f_i;
      sda_p_q <= sda_f_i;
    end
  end

  assign scl_rise_o = scl_f_i & ~scl_p_q;
  assign scl_fall_o = ~scl_f_i & scl_p_q;
  assign start_o    = scl_f_i & scl_p_q & sda_p_q & ~sda_f_i;
  assign stop_o     = scl_f_i & scl_p_q & ~sda_p_q & sda_f_i;
endmodule

// File: rtl/i2c_cmd_core.sv
module i2c_cmd_core
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] TGT_ADDR = 7'b1001001
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_f_i,
  input  logic              sda_f_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  output logic              sda_oe_o,
  output logic [PTR_W-1:0]  reg_sel_o,
  output logic              reg_wr_o,
  output logic [BYTE_W-1:0] reg_wdata_o,
  output logic              reg_rd_o,
  input  logic [BYTE_W-1:0] reg_rdata_i
);
  localparam logic [BCNT_W-1:0] BITS = BCNT_W'(BYTE_W);

  tgt_state_e         state_q;
  logic [BCNT_W-1:0]  bit_q;
  logic [BYTE_W-1:0]  sh_q;
  logic               rw_q, cmd_pend_q, nack_q, oe_q, wr_q;
  logic [PTR_W-1:0]   ptr_q;
  logic [BYTE_W-1:0]  wdata_q;

  // load a byte to send: after address ACK on read, or after master ACK
  assign reg_rd_o = scl_fall_i & ~start_i & ~stop_i &
                    (((state_q == ST_AACK) & rw_q) | ((state_q == ST_MACK) & ~nack_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      bit_q      <= '0;
      sh_q       <= '0;
      rw_q       <= 1'b0;
      cmd_pend_q <= 1'b0;
      nack_q     <= 1'b0;
      oe_q       <= 1'b0;
      wr_q       <= 1'b0;
      ptr_q      <= '0;
      wdata_q    <= '0;
    end else begin
      wr_q <= 1'b0;
      if (stop_i) begin
        state_q <= ST_IDLE;
        oe_q    <= 1'b0;
      end else if (start_i) begin
        state_q <= ST_ADDR;
        bit_q   <= '0;
        oe_q    <= 1'b0;
      end else begin
        unique case (state_q)
          ST_ADDR, ST_RX: begin
            if (scl_rise_i) begin
              sh_q  <= {sh_q[BYTE_W-2:0], sda_f_i};
              bit_q <= bit_q + BCNT_W'(1);
            end else if (scl_fall_i && bit_q == BITS) begin
              if (state_q == ST_RX) begin
                oe_q    <= 1'b1;
                state_q <= ST_RACK;
              end else if (sh_q[BYTE_W-1:1] == TGT_ADDR) begin
                oe_q       <= 1'b1;
                rw_q       <= sh_q[0];
                cmd_pend_q <= ~sh_q[0];
                state_q    <= ST_AACK;
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          ST_AACK: if (scl_fall_i) begin
            bit_q <= '0;
            if (rw_q) begin
              sh_q    <= reg_rdata_i;
              oe_q    <= ~reg_rdata_i[BYTE_W-1];
              state_q <= ST_TX;
            end else begin
              oe_q    <= 1'b0;
              state_q <= ST_RX;
            end
          end
          ST_RACK: begin
            if (scl_rise_i) begin
              if (cmd_pend_q) ptr_q <= sh_q[PTR_W-1:0];
              else begin
                wr_q    <= 1'b1;
                wdata_q <= sh_q;
              end
            end else if (scl_fall_i) begin
              oe_q       <= 1'b0;
              cmd_pend_q <= 1'b0;
              bit_q      <= '0;
              state_q    <= ST_RX;
            end
          end
          ST_TX: begin
            if (scl_rise_i) begin
              bit_q <= bit_q + BCNT_W'(1);
            end else if (scl_fall_i) begin
              if (bit_q == BITS) begin
                oe_q    <= 1'b0;
                state_q <= ST_MACK;
              end else begin
                sh_q <= {sh_q[BYTE_W-2:0], 1'b0};
                oe_q <= ~sh_q[BYTE_W-2];
              end
            end
          end
          ST_MACK: begin
            if (scl_rise_i) begin
              nack_q <= sda_f_i;
            end else if (scl_fall_i) begin
              if (nack_q) begin
                state_q <= ST_IDLE;
              end else begin
                bit_q   <= '0;
                sh_q    <= reg_rdata_i;
                oe_q    <= ~reg_rdata_i[BYTE_W-1];
                state_q <= ST_TX;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o    = oe_q;
  assign reg_sel_o   = ptr_q;
  assign reg_wr_o    = wr_q;
  assign reg_wdata_o = wdata_q;

  // R11
  sda_scl_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !scl_f_i);
  // R9
  wr_in_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_o |-> (sda_oe_o && scl_f_i));
  // R4
  wr_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_o |=> !reg_wr_o);
  // R8
  stop_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !sda_oe_o);
  // R3
  sel_on_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(reg_sel_o) |-> sda_oe_o);
  // R6
  rd_scl_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rd_o |-> (!scl_f_i && !reg_wr_o));
endmodule

// File: rtl/i2c_cmd_target.sv
module i2c_cmd_target #(
  parameter logic [6:0] TGT_ADDR = 7'b1001001,
  parameter int         FILT_CYC = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  output logic [1:0] reg_sel_o,
  output logic       reg_wr_o,
  output logic [7:0] reg_wdata_o,
  output logic       reg_rd_o,
  input  logic [7:0] reg_rdata_i
);
  logic [1:0] raw, flt;
  logic       scl_rise, scl_fall, start_det, stop_det;

  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_flt
    i2c_line_filter #(.FILT_CYC(FILT_CYC)) u_flt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .raw_i (raw[g]),
      .flt_o (flt[g])
    );
  end

  i2c_bus_events u_evt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_f_i   (flt[0]),
    .sda_f_i   (flt[1]),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (start_det),
    .stop_o    (stop_det)
  );

  i2c_cmd_core #(.TGT_ADDR(TGT_ADDR)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_f_i    (flt[0]),
    .sda_f_i    (flt[1]),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start_det),
    .stop_i     (stop_det),
    .sda_oe_o   (sda_oe_o),
    .reg_sel_o  (reg_sel_o),
    .reg_wr_o   (reg_wr_o),
    .reg_wdata_o(reg_wdata_o),
    .reg_rd_o   (reg_rd_o),
    .reg_rdata_i(reg_rdata_i)
  );
endmodule

// File: tb/i2c_cmd_target_tb_top.sv
module i2c_cmd_target_tb_top;
  localparam int         TQ    = 25;
  localparam logic [6:0] TADDR = 7'b1001001;
  localparam int         NVEC  = 5;
  // {command byte, data byte}
  localparam logic [15:0] VEC [NVEC] = '{16'h00A5, 16'h013C, 16'hFE77, 16'h03C8, 16'h8E5A};

  logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, reg_wr, reg_rd;
  logic [1:0] reg_sel;
  logic [7:0] reg_wdata, reg_rdata;
  logic [7:0] bank [4] = '{default: 8'h00};
  int n_chk = 0, n_bad = 0, wr_cnt = 0, rd_cnt = 0, oe_viol = 0, mid_wr = 0;
  logic oe_d = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  wire sda_line = sda_m & ~sda_oe;
  assign reg_rdata = bank[reg_sel];

  i2c_cmd_target dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .reg_sel_o(reg_sel), .reg_wr_o(reg_wr),
    .reg_wdata_o(reg_wdata), .reg_rd_o(reg_rd), .reg_rdata_i(reg_rdata)
  );

  always @(posedge clk) begin
    if (reg_wr) begin bank[reg_sel] <= reg_wdata; wr_cnt <= wr_cnt + 1; end
    if (reg_rd) rd_cnt <= rd_cnt + 1;
    oe_d <= sda_oe;
    if (rst_n && (sda_oe != oe_d) && scl_m) oe_viol <= oe_viol + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n); repeat (n) @(negedge clk); endtask

  task automatic bit_x(input logic b, output logic s);
    sda_m = b; wq(TQ); scl_m = 1'b1; wq(TQ);
    s = sda_line; mid_wr = wr_cnt;
    wq(TQ); scl_m = 1'b0; wq(TQ);
  endtask

  // mode 1: short SCL pulse in low phase; mode 2: short SDA dip in high phase
  task automatic bit_g(input logic b, input int mode);
    sda_m = b; wq(10);
    if (mode == 1) begin scl_m = 1'b1; wq(4); scl_m = 1'b0; wq(TQ - 14); end
    else wq(TQ - 10);
    scl_m = 1'b1; wq(TQ);
    if (mode == 2) begin sda_m = 1'b0; wq(4); sda_m = b; wq(2 * TQ - 4); end
    else wq(2 * TQ);
    scl_m = 1'b0; wq(TQ);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; wq(TQ); scl_m = 1'b1; wq(2 * TQ);
    sda_m = 1'b0; wq(2 * TQ); scl_m = 1'b0; wq(TQ);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; wq(TQ); scl_m = 1'b1; wq(2 * TQ);
    sda_m = 1'b1; wq(2 * TQ);
  endtask

  task automatic tx_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_x(b[i], s);
    bit_x(1'b1, s);
    ack = ~s;
  endtask

  task automatic rx_byte(input logic mack, output logic [7:0] d);
    logic s;
    d = '0;
    for (int i = 0; i < 8; i++) begin bit_x(1'b1, s); d = {d[6:0], s}; end
    bit_x(~mack, s);
  endtask

  task automatic wr_reg(input logic [7:0] cmd, input logic [7:0] data);
    logic a;
    bus_start;
    tx_byte({TADDR, 1'b0}, a); chk("R2 address ack", a, 1);
    tx_byte(cmd, a);           chk("R3 command ack", a, 1);
    tx_byte(data, a);          chk("R2 data ack", a, 1);
    bus_stop;
  endtask

  task automatic rd_rs(input logic [7:0] cmd, output logic [7:0] d);
    logic a;
    bus_start;
    tx_byte({TADDR, 1'b0}, a); chk("R2 address ack", a, 1);
    tx_byte(cmd, a);           chk("R3 command ack", a, 1);
    bus_start;
    tx_byte({TADDR, 1'b1}, a); chk("R6 read address ack", a, 1);
    rx_byte(1'b0, d);
    bus_stop;
  endtask

  initial begin
    logic a;
    logic [7:0] d;
    int w0, r0;
    wq(5);
    chk("R1 sda_oe after reset", sda_oe, 0);
    chk("R1 reg_wr after reset", reg_wr, 0);
    chk("R1 reg_rd after reset", reg_rd, 0);
    chk("R1 reg_sel after reset", reg_sel, 0);
    rst_n = 1'b1; wq(20);
    chk("R1 reg_sel after release", reg_sel, 0);

    // R3 R6: write through command byte, read back through repeated START
    for (int v = 0; v < NVEC; v++) begin
      wr_reg(VEC[v][15:8], VEC[v][7:0]);
      chk("R3 select from low command bits", reg_sel, 32'(VEC[v][9:8]));
      rd_rs(VEC[v][15:8], d);
      chk("R6 read-back MSB first", d, VEC[v][7:0]);
    end
    // regs now: 0=A5 1=3C 2=5A 3=C8, sel=2

    // R2 wrong address
    w0 = wr_cnt;
    bus_start;
    tx_byte(8'h90, a); chk("R2 wrong address nack", a, 0);
    tx_byte(8'h01, a); chk("R2 no ack after wrong address", a, 0);
    tx_byte(8'h11, a);
    bus_stop;
    chk("R2 no write on wrong address", wr_cnt, w0);
    chk("R2 selection untouched", reg_sel, 2);

    // R4 R9 multi-byte write, no increment, strobe in ack clock
    w0 = wr_cnt;
    bus_start;
    tx_byte({TADDR, 1'b0}, a);
    tx_byte(8'h01, a);
    chk("R3 command byte gives no strobe", wr_cnt, w0);
    for (int k = 1; k <= 3; k++) begin
      logic s;
      for (int i = 7; i >= 0; i--) bit_x(k[i] ? 1'b1 : 1'b0, s);
      chk("R9 no strobe before ack clock", wr_cnt, w0 + k - 1);
      bit_x(1'b1, s);
      chk("R9 strobe inside ack clock", mid_wr, w0 + k);
      chk("R4 data ack", s, 0);
    end
    bus_stop;
    chk("R4 one strobe per byte", wr_cnt, w0 + 3);
    chk("R4 last byte in same register", bank[1], 8'h03);
    chk("R4 reg0 untouched", bank[0], 8'hA5);
    chk("R4 reg2 untouched", bank[2], 8'h5A);

    // R5 R7 current-pointer read of three bytes
    r0 = rd_cnt;
    bus_start;
    tx_byte({TADDR, 1'b1}, a); chk("R5 read address ack", a, 1);
    for (int k = 0; k < 3; k++) begin
      rx_byte(k != 2, d);
      chk("R5 sticky pointer read", d, 8'h03);
    end
    chk("R7 released after master nack", sda_oe, 0);
    bus_stop;
    chk("R7 no load after nack", rd_cnt, r0 + 3);
    chk("R5 selection persists", reg_sel, 1);

    // R8 STOP inside a data byte
    w0 = wr_cnt;
    bus_start;
    tx_byte({TADDR, 1'b0}, a);
    tx_byte(8'h02, a);
    for (int i = 0; i < 4; i++) begin logic s; bit_x(1'b1, s); end
    bus_stop;
    wq(20);
    chk("R8 truncated byte not written", wr_cnt, w0);
    chk("R8 SDA released after stop", sda_oe, 0);
    bus_start;
    tx_byte({TADDR, 1'b1}, a); chk("R8 accepts next transfer", a, 1);
    rx_byte(1'b0, d);
    bus_stop;
    chk("R8 read after aborted write", d, 8'h5A);

    // R10 glitch rejection during data byte 0xA6
    w0 = wr_cnt;
    bus_start;
    tx_byte({TADDR, 1'b0}, a);
    tx_byte(8'h03, a);
    for (int i = 7; i >= 0; i--) bit_g(8'hA6 >> i & 1, (i == 3) ? 1 : (i == 5) ? 2 : 0);
    begin logic s; bit_x(1'b1, s); chk("R10 ack despite glitches", s, 0); end
    bus_stop;
    chk("R10 single write", wr_cnt, w0 + 1);
    chk("R10 glitch-free data", bank[3], 8'hA6);

    chk("R11 SDA changes only with SCL low", oe_viol, 0);

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule